// File: doc/BRIEF.md
# Serial Register Target with Chained and Shared-Select Outputs

This block is a serial-peripheral target that lets a host controller read and write a bank of 8-bit registers. A transfer, framed by an active-low select, carries an address byte and then a data byte, most significant bit first. The address byte holds three fields: a two-bit device identity, a read flag and a register index. Input bits are taken on the rising serial clock edge, and outputs move only on the falling edge. Either clock idle level works.

A strap picks one of two wirings. In chained wiring the chain output `soc` replays the input stream sixteen clocks later, so the next device in a ring receives its own frame. The first sixteen bits of each transfer carry a response word that the previous transfer loaded. That word is a fixed status byte, followed by register contents if the previous frame was a valid read. In shared wiring all devices see the same select. Only the device whose identity straps match the address byte drives `sob` during the data phase. It sends the register for a read and the status byte for a write, and it keeps `sob_oe` low at all other times.

The serial pins are brought into the system clock domain through two-stage synchronisers, so the serial clock must be much slower than `clk`.

Top module: `spi_tgt_top`

## Requirements
- R1: Input bits are sampled on rising `sck` edges while `ncs` is low, and the result does not depend on whether `sck` idles low or high.
- R2: A frame is 16 bits, MSB first: address byte then data byte. Address bits [7:6] are the device identity, bit 5 is read (1) or write (0), and bits [4:0] index one of 32 registers.
- R3: `soc` and `sob` change only after a falling `sck` edge, or after an `ncs` edge. The first chained output bit is valid as soon as `ncs` falls.
- R4: With `strap_bus`=0, for bit k of a transfer, `soc` shows response bit 15-k when k<16 and input bit k-16 otherwise. `sob_oe` stays low.
- R5: With `strap_bus`=1, a write frame commits its data byte when `ncs` rises after exactly 16 clocks and bits [7:6] equal `strap_id`.
- R6: In shared wiring a matching read drives `sob_oe` high from bit 8, and `sob` carries the indexed register MSB first on bits 8 to 15. `sob_oe` is low during bits 0 to 7.
- R7: In shared wiring a frame whose identity differs from `strap_id` leaves `sob_oe` low throughout and writes nothing.
- R8: A frame ended with a clock count that is not valid for the wiring writes nothing, and the bit counter restarts whenever `ncs` is high.
- R9: In chained wiring, a transfer whose clock count is a nonzero multiple of 16 is decoded from its last 16 bits, ignoring the identity field. A write frame commits.
- R10: The response word is {status 8'hA5, register} after a valid read frame, and {8'hA5, 8'h00} after any other transfer or after reset.
- R11: A matching write frame in shared wiring drives the status byte 8'hA5 on `sob` during bits 8 to 15.
- R12: After reset all registers are zero, `soc` is 0 and `sob_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| ncs | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| strap_bus | input | 1 | Wiring strap: 0 chained, 1 shared select |
| strap_id | input | 2 | Device identity strap for shared wiring |
| soc | output | 1 | Chain output to the next device |
| sob | output | 1 | Shared-line data, held 0 when not driven |
| sob_oe | output | 1 | Drive enable for the shared line (high-impedance when 0) |

## Verification
The hardest state to reach from the ports is the chained readback. It spans two transfers: a read frame must sit in the last 16 bits of a longer chained transfer, and its result only appears at the start of the next transfer. The stimulus builds 32-bit and 24-bit chained transfers whose tail holds a read, a write or nothing decodable. The following transfer then checks both the response word and the sixteen-clock replay of the earlier input. Shared-wiring frames that are too short, too long or carry a foreign identity are mixed in, so the reference model can show that none of them changes a register.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    // field positions inside the address byte (decoded by the engine and the host)
    localparam int unsigned ID_HI  = 7;
    localparam int unsigned ID_LO  = 6;
    localparam int unsigned RD_BIT = 5;
    localparam int unsigned ID_W   = ID_HI - ID_LO + 1;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
            prev_q <= prev_d;
        end
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_edge
            assign lvl_o[b]  = stg_q[STAGES-1][b];
            assign rise_o[b] = stg_q[STAGES-1][b] & ~prev_q[b];
            assign fall_o[b] = ~stg_q[STAGES-1][b] & prev_q[b];
        end
    endgenerate
endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned REG_N  = 32,
    localparam int unsigned ADDR_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bank_d [REG_N];
    logic [WORD_W-1:0] bank_q [REG_N];

    always_comb begin
        for (int r = 0; r < REG_N; r++) bank_d[r] = bank_q[r];
        if (wr_en) bank_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < REG_N; r++) bank_q[r] <= '0;
        end else begin
            for (int r = 0; r < REG_N; r++) bank_q[r] <= bank_d[r];
        end
    end

    assign rd_data = bank_q[rd_addr];
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 8,
    parameter logic [WORD_W-1:0] STATUS = 8'hA5,
    localparam int unsigned FRAME_W = 2 * WORD_W,
    localparam int unsigned FLOG    = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              si_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              ncs_s,
    input  logic              ncs_rise,
    input  logic              ncs_fall,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              soc_o,
    output logic              sob_o,
    output logic              oe_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] WORD_CNT  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
        logic [WORD_W-1:0]  out;
        logic               soc;
        logic               sob;
        logic               oe;
    } eng_t;

    eng_t st_d, st_q;

    logic [WORD_W-1:0] addr_word, data_word, low_word, load_word;
    logic              end_hit, end_valid, end_rd, addr_hit;

    always_comb begin
        addr_word = st_q.sr[FRAME_W-1 -: WORD_W];
        data_word = st_q.sr[WORD_W-1:0];
        low_word  = st_q.sr[WORD_W-1:0];
        end_hit   = (addr_word[ID_HI:ID_LO] == dev_id);
        end_rd    = addr_word[RD_BIT];
        if (bus_mode)
            end_valid = (st_q.cnt == FRAME_CNT) && end_hit;
        else
            end_valid = (st_q.cnt != '0) && (st_q.cnt[FLOG-1:0] == '0);
        addr_hit  = (low_word[ID_HI:ID_LO] == dev_id);
        // address byte sits in the low half right after the eighth clock
        rd_addr   = (st_q.cnt == WORD_CNT) ? low_word[ADDR_W-1:0]
                                            : addr_word[ADDR_W-1:0];
        load_word = low_word[RD_BIT] ? rd_data : STATUS;
    end

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = addr_word[ADDR_W-1:0];
        wr_data = data_word;
        if (ncs_rise) begin
            wr_en    = end_valid && !end_rd;
            st_d.sr  = {STATUS, (end_valid && end_rd) ? rd_data : '0};
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
            st_d.sob = 1'b0;
            st_d.out = '0;
        end else if (ncs_s) begin
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
            st_d.sob = 1'b0;
        end else if (ncs_fall) begin
            st_d.cnt = '0;
            st_d.soc = st_q.sr[FRAME_W-1];
        end else begin
            if (sck_rise) begin
                st_d.sr  = {st_q.sr[FRAME_W-2:0], si_s};
                st_d.cnt = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
            end
            if (sck_fall) begin
                st_d.soc = st_q.sr[FRAME_W-1];
                if (bus_mode) begin
                    if (st_q.cnt == WORD_CNT) begin
                        if (addr_hit) begin
                            st_d.oe  = 1'b1;
                            st_d.sob = load_word[WORD_W-1];
                            st_d.out = {load_word[WORD_W-2:0], 1'b0};
                        end
                    end else if (st_q.cnt > WORD_CNT && st_q.oe) begin
                        st_d.sob = st_q.out[WORD_W-1];
                        st_d.out = {st_q.out[WORD_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.sr  <= {STATUS, {WORD_W{1'b0}}};
            st_q.out <= '0;
            st_q.soc <= 1'b0;
            st_q.sob <= 1'b0;
            st_q.oe  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign soc_o = st_q.soc;
    assign sob_o = st_q.sob;
    assign oe_o  = st_q.oe;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/spi_tgt_top.sv
module spi_tgt_top
    import spi_tgt_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned REG_N  = 32,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] STATUS = 8'hA5,
    localparam int unsigned ADDR_W = $clog2(REG_N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck,
    input  logic            ncs,
    input  logic            si,
    input  logic            strap_bus,
    input  logic [ID_W-1:0] strap_id,
    output logic            soc,
    output logic            sob,
    output logic            sob_oe
);
    // pin order inside the synchroniser: 2 = ncs, 1 = sck, 0 = si
    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic ncs_s, ncs_rise, ncs_fall, sck_rise, sck_fall, si_s;

    spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i({ncs, sck, si}),
        .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    assign ncs_s    = pin_lvl[2];
    assign ncs_rise = pin_rise[2];
    assign ncs_fall = pin_fall[2];
    assign sck_rise = pin_rise[1];
    assign sck_fall = pin_fall[1];
    assign si_s     = pin_lvl[0];

    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic              wr_en, soc_q, sob_q, oe_q;
    logic [CNT_W-1:0]  bit_cnt;

    spi_tgt_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STATUS(STATUS)) eng_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(strap_bus), .dev_id(strap_id),
        .si_s(si_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .ncs_s(ncs_s), .ncs_rise(ncs_rise), .ncs_fall(ncs_fall),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .soc_o(soc_q), .sob_o(sob_q), .oe_o(oe_q), .cnt_o(bit_cnt)
    );

    spi_tgt_regs #(.WORD_W(WORD_W), .REG_N(REG_N)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign soc    = strap_bus ? 1'b0 : soc_q;
    assign sob_oe = strap_bus & oe_q;
    assign sob    = sob_oe & sob_q;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_bus,
    input logic             ncs_s,
    input logic             ncs_rise,
    input logic             ncs_fall,
    input logic             sck_fall,
    input logic             soc,
    input logic             sob,
    input logic             sob_oe,
    input logic             wr_en,
    input logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] WORD_CNT  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(2 * WORD_W);

    // R3: chain output moves only after a falling clock or select edge
    assert_soc_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(soc) && $stable(strap_bus)) |-> $past(sck_fall || ncs_fall));

    // R3: shared-line data moves only after a falling clock or end of frame
    assert_sob_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sob) && $stable(strap_bus)) |-> $past(sck_fall || ncs_rise));

    // R6: the shared line is never driven during the address phase
    assert_oe_data_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sob_oe |-> (bit_cnt >= WORD_CNT));

    // R7: the drive is released once the frame ends
    assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ncs_rise |=> !sob_oe);

    // R8: the bit counter is cleared while the select is high
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ncs_s |=> (bit_cnt == '0));

    // R5: a shared-wiring write only commits after exactly one frame
    assert_bus_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && strap_bus) |-> (bit_cnt == FRAME_CNT));

    // R9: writes happen only at the end of a transfer
    assert_wr_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ncs_rise);
endmodule

bind spi_tgt_top spi_tgt_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .strap_bus(strap_bus), .ncs_s(ncs_s),
    .ncs_rise(ncs_rise), .ncs_fall(ncs_fall), .sck_fall(sck_fall),
    .soc(soc), .sob(sob), .sob_oe(sob_oe), .wr_en(wr_en), .bit_cnt(bit_cnt)
);

// File: tb/spi_tgt_top_tb_top.sv
module spi_tgt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam logic [7:0] ST = 8'hA5;

    logic clk = 1'b0;
    logic rst_n, sck, ncs, si, strap_bus;
    logic [1:0] strap_id;
    logic soc, sob, sob_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]   mref [32];
    logic [15:0]  resp;
    logic [255:0] tx;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_tgt_top dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ncs(ncs), .si(si),
        .strap_bus(strap_bus), .strap_id(strap_id),
        .soc(soc), .sob(sob), .sob_oe(sob_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fr(input logic [1:0] id, input logic rd,
                                      input logic [4:0] a, input logic [7:0] d);
        return {id, rd, a, d};
    endfunction

    // one transfer of n bits taken from tx[n-1:0], first bit = tx[n-1]
    task automatic run_frame(input bit cpol, input int n);
        logic [255:0] e_soc, e_sob, e_oe;
        logic         match, rd, valid;
        logic [4:0]   idx;
        logic [7:0]   val;
        logic [15:0]  last16;
        match = (n >= 8) && (tx[n-1 -: 2] == strap_id);
        rd    = (n >= 8) && tx[n-3];
        idx   = (n >= 8) ? tx[n-4 -: 5] : 5'd0;
        val   = rd ? mref[idx] : ST;
        e_soc = '0; e_sob = '0; e_oe = '0;
        for (int i = 0; i < n; i++) begin
            if (!strap_bus) begin
                e_soc[i] = (i < 16) ? resp[15-i] : tx[n-1-(i-16)];
            end else begin
                e_oe[i]  = (i >= 8) && match;
                e_sob[i] = (i >= 8 && i < 16 && match) ? val[15-i] : 1'b0;
            end
        end
        @(negedge clk);
        sck = cpol;
        ncs = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (cpol) sck = 1'b0;
            si = tx[n-1-i];
            repeat (HALF) @(negedge clk);
            if (!strap_bus) begin
                chk(soc === e_soc[i], "R4 chain output bit", 16'(soc), 16'(e_soc[i]));
                chk(sob_oe === 1'b0, "R4 shared drive off in chain", 16'(sob_oe), 16'h0);
            end else begin
                chk(sob_oe === e_oe[i], (match ? "R6 drive enable" : "R7 foreign id drive"),
                    16'(sob_oe), 16'(e_oe[i]));
                if (e_oe[i])
                    chk(sob === e_sob[i], (rd ? "R6 read data" : "R11 status byte"),
                        16'(sob), 16'(e_sob[i]));
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (!cpol) sck = 1'b0;
        end
        ncs = 1'b1;
        repeat (2*HALF) @(negedge clk);
        chk(sob_oe === 1'b0, "R7 drive released", 16'(sob_oe), 16'h0);
        // model update at end of transfer (R5, R8, R9, R10)
        last16 = tx[15:0];
        if (strap_bus) valid = (n == 16) && (last16[15:14] == strap_id);
        else           valid = (n > 0) && (n % 16 == 0);
        if (valid && !last16[13]) mref[last16[12:8]] = last16[7:0];
        resp = {ST, (valid && last16[13]) ? mref[last16[12:8]] : 8'h00};
    endtask

    task automatic bus_read(input bit cpol, input logic [4:0] a);
        tx = '0; tx[15:0] = fr(strap_id, 1'b1, a, 8'h00);
        run_frame(cpol, 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 32; r++) mref[r] = 8'h00;
        resp = {ST, 8'h00};
        rst_n = 1'b0; ncs = 1'b1; sck = 1'b0; si = 1'b0;
        strap_bus = 1'b1; strap_id = 2'b10;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(soc === 1'b0, "R12 chain output after reset", 16'(soc), 16'h0);
        chk(sob_oe === 1'b0, "R12 shared drive after reset", 16'(sob_oe), 16'h0);
        bus_read(1'b0, 5'd5);                                // R12 register reads zero

        // R1 R2 R5 R6: write in idle-low, read back in idle-high
        tx = '0; tx[15:0] = fr(2'b10, 1'b0, 5'd5, 8'h3C); run_frame(1'b0, 16);
        bus_read(1'b1, 5'd5);
        tx = '0; tx[15:0] = fr(2'b10, 1'b0, 5'd31, 8'hAA); run_frame(1'b1, 16);
        bus_read(1'b0, 5'd31);

        // R7: foreign identity neither drives nor writes
        tx = '0; tx[15:0] = fr(2'b01, 1'b0, 5'd5, 8'hFF); run_frame(1'b0, 16);
        tx = '0; tx[15:0] = fr(2'b11, 1'b1, 5'd5, 8'h00); run_frame(1'b1, 16);
        bus_read(1'b0, 5'd5);

        // R8: short and long frames are discarded
        tx = '0; tx[11:0] = 12'h8C7; run_frame(1'b0, 12);    // 10_0_01100 then 0111
        tx = '0; tx[19:0] = {fr(2'b10, 1'b0, 5'd6, 8'h5A), 4'h3}; run_frame(1'b1, 20);
        bus_read(1'b0, 5'd6);

        // R11 plus a spread of writes and reads
        for (int k = 0; k < 6; k++) begin
            tx = '0; tx[15:0] = fr(2'b10, 1'b0, 5'(k*5+1), 8'(k*37+11));
            run_frame(k[0], 16);
        end
        for (int k = 0; k < 6; k++) bus_read(~k[0], 5'(k*5+1));

        // chained wiring: R4 R9 R10
        strap_bus = 1'b0;
        repeat (4) @(negedge clk);
        tx = '0; tx[15:0] = fr(2'b11, 1'b0, 5'd7, 8'h81); run_frame(1'b0, 16);
        tx = '0; tx[31:0] = {16'hC3E1, fr(2'b00, 1'b1, 5'd7, 8'h00)}; run_frame(1'b1, 32);
        tx = '0; tx[15:0] = 16'h1234; run_frame(1'b0, 16);   // R10 readback of 8'h81
        tx = '0; tx[23:0] = {8'h00, fr(2'b01, 1'b0, 5'd7, 8'hEE)}; run_frame(1'b1, 24);
        tx = '0; tx[47:0] = {16'hFFFF, 16'h0F0F, fr(2'b01, 1'b1, 5'd31, 8'h00)}; run_frame(1'b0, 48);
        tx = '0; tx[15:0] = fr(2'b10, 1'b1, 5'd1, 8'h00); run_frame(1'b1, 16);
        tx = '0; tx[15:0] = 16'h0000; run_frame(1'b0, 16);

        // back to shared wiring: chained writes landed, aborted one did not
        strap_bus = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(1'b0, 5'd7);
        bus_read(1'b1, 5'd31);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule